// File: doc/BRIEF.md
# Grouped Programmable Interrupt Priority Resolver

This block chooses one winner among six interrupt lines, numbered 0 to 5, on every clock cycle. A line competes only when it is pending, its mask bit allows it, and the global enable is high. The lines are fixed into three pairs. Group A holds lines 3 and 5, group B holds lines 0 and 2, and group C holds lines 1 and 4. A 3-bit code selects the order of the three groups. One bit per group selects which member of that pair comes first.

The ordering is held in an 8-bit configuration register. Software writes it through a write strobe and cannot read it back. Two of its code values are illegal, and while either is loaded no line can win. The resolver reports its result through two registered outputs, a valid flag and a 3-bit line index. Both describe the inputs and configuration as they stood at the previous rising clock edge.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `win_valid` is 0, `win_idx` is 0 and the configuration register holds 8'h00. That value carries an illegal group code, so no line wins until software writes the register.
- R2: A line `k` is eligible only when `irq_pend[k]`, `irq_mask[k]` (1 means allowed) and `irq_en` are all 1. When no line is eligible, `win_valid` is 0.
- R3: The group-order code is formed from register bits {4,2,1}, with bit 4 as the MSB. The codes map as follows: 3'b010 is A>B>C, 3'b011 is A>C>B, 3'b110 is B>A>C, 3'b100 is B>C>A, 3'b001 is C>A>B and 3'b101 is C>B>A. The winner is the first eligible line in the resulting six-slot order.
- R4: Register bit 5 orders group A. A value of 0 puts line 5 ahead of line 3, and a value of 1 puts line 3 ahead of line 5.
- R5: Register bit 3 orders group B. A value of 0 puts line 2 ahead of line 0, and a value of 1 puts line 0 ahead of line 2.
- R6: Register bit 0 orders group C. A value of 0 puts line 1 ahead of line 4, and a value of 1 puts line 4 ahead of line 1.
- R7: Group codes 3'b000 and 3'b111 are illegal. While either is loaded, `win_valid` is 0 whatever the requests are.
- R8: Register bits 7:6 are reserved and have no effect on the result.
- R9: `win_valid` and `win_idx` reflect the inputs sampled at the previous rising edge. `win_idx` is 0 whenever `win_valid` is 0.
- R10: The register loads `cfg_wdata` only at a rising edge where `cfg_we` is 1. At all other edges it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the priority register |
| cfg_wdata | input | 8 | Data written to the priority register |
| irq_pend | input | 6 | Pending request per line |
| irq_mask | input | 6 | Per-line allow bit, 1 means the line may compete |
| irq_en | input | 1 | Global interrupt enable |
| win_valid | output | 1 | A winner exists (registered) |
| win_idx | output | 3 | Index of the winning line, 0 when there is no winner (registered) |

## Verification
The bench writes each of the 256 register values, including every reserved-bit combination. For each value it applies all 64 pending patterns with every line allowed. This separates the six legal group orders from the two illegal codes, and it tests each pair-order bit against every combination of competing lines. For two register values the bench then crosses all 64 pending patterns with all 64 mask patterns. This shows that masked lines never win, even when they outrank the lines that are allowed. Directed cases cover the remaining behaviour: a lowered global enable, each pair-order bit with both members pending, a one-cycle output latency, and a write attempted with the strobe low.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_IRQ = 6;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int CFG_W   = 8;
    localparam int NUM_GRP = NUM_IRQ / 2;
    localparam int GRP_W   = $clog2(NUM_GRP);
    localparam int CODE_W  = 3;

    // Register bit positions decoded by the resolver
    localparam int BIT_CODE2 = 4;
    localparam int BIT_CODE1 = 2;
    localparam int BIT_CODE0 = 1;
    localparam int BIT_ORD_A = 5;
    localparam int BIT_ORD_B = 3;
    localparam int BIT_ORD_C = 0;

    // Group identifiers (pair order within the packed arrays)
    localparam logic [GRP_W-1:0] GID_A = 2'd0;
    localparam logic [GRP_W-1:0] GID_B = 2'd1;
    localparam logic [GRP_W-1:0] GID_C = 2'd2;

    // Member that leads when the pair-order bit is 0, and the other one
    localparam int PAIR_LEAD  [NUM_GRP] = '{5, 2, 1};
    localparam int PAIR_TRAIL [NUM_GRP] = '{3, 0, 4};

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [NUM_GRP-1:0] swap;   // indexed by group id
    } prio_fields_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic prio_fields_t split_cfg(input logic [CFG_W-1:0] r);
        prio_fields_t f;
        f.code        = {r[BIT_CODE2], r[BIT_CODE1], r[BIT_CODE0]};
        f.swap[GID_A] = r[BIT_ORD_A];
        f.swap[GID_B] = r[BIT_ORD_B];
        f.swap[GID_C] = r[BIT_ORD_C];
        return f;
    endfunction

endpackage

// File: rtl/irq_prio_cfg.sv
module irq_prio_cfg
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output prio_fields_t     fields
);

    typedef struct packed {
        logic [CFG_W-1:0] raw;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.raw = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields = split_cfg(st_q.raw);

    // R10: without a strobe the stored value never moves
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q));

    // R10: a strobed write lands in the register
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (st_q.raw == $past(cfg_wdata)));

endmodule

// File: rtl/irq_pair_pick.sv
module irq_pair_pick
    import irq_prio_pkg::*;
#(
    parameter int LEAD  = 0,
    parameter int TRAIL = 1
) (
    input  logic [NUM_IRQ-1:0] elig,
    input  logic               swap,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    localparam logic [IDX_W-1:0] LEAD_IDX  = IDX_W'(LEAD);
    localparam logic [IDX_W-1:0] TRAIL_IDX = IDX_W'(TRAIL);

    logic first_req, second_req;
    logic [IDX_W-1:0] first_idx, second_idx;

    always_comb begin
        if (swap) begin
            first_req  = elig[TRAIL];
            first_idx  = TRAIL_IDX;
            second_req = elig[LEAD];
            second_idx = LEAD_IDX;
        end else begin
            first_req  = elig[LEAD];
            first_idx  = LEAD_IDX;
            second_req = elig[TRAIL];
            second_idx = TRAIL_IDX;
        end
        any = first_req | second_req;
        if (first_req) begin
            idx = first_idx;
        end else if (second_req) begin
            idx = second_idx;
        end else begin
            idx = '0;
        end
    end

endmodule

// File: rtl/irq_group_rank.sv
module irq_group_rank
    import irq_prio_pkg::*;
(
    input  logic [CODE_W-1:0]             code,
    output logic                          code_ok,
    output logic [NUM_GRP-1:0][GRP_W-1:0] rank   // rank[0] is served first
);

    always_comb begin
        code_ok = 1'b1;
        rank    = {GID_C, GID_B, GID_A};
        unique case (code)
            3'b001: rank = {GID_B, GID_A, GID_C};
            3'b010: rank = {GID_C, GID_B, GID_A};
            3'b011: rank = {GID_B, GID_C, GID_A};
            3'b100: rank = {GID_A, GID_C, GID_B};
            3'b101: rank = {GID_A, GID_B, GID_C};
            3'b110: rank = {GID_C, GID_A, GID_B};
            default: code_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               irq_en,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);

    prio_fields_t                  fields;
    logic [NUM_IRQ-1:0]            elig;
    logic [NUM_GRP-1:0]            grp_any;
    logic [NUM_GRP-1:0][IDX_W-1:0] grp_idx;
    logic [NUM_GRP-1:0][GRP_W-1:0] rank;
    logic                          code_ok;
    win_t                          win_d, win_q;

    irq_prio_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .fields    (fields)
    );

    assign elig = irq_en ? (irq_pend & irq_mask) : '0;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
        irq_pair_pick #(
            .LEAD  (PAIR_LEAD[g]),
            .TRAIL (PAIR_TRAIL[g])
        ) u_pick (
            .elig (elig),
            .swap (fields.swap[g]),
            .any  (grp_any[g]),
            .idx  (grp_idx[g])
        );
    end

    irq_group_rank u_rank (
        .code    (fields.code),
        .code_ok (code_ok),
        .rank    (rank)
    );

    always_comb begin
        logic found;
        found = 1'b0;
        win_d = '0;
        for (int r = 0; r < NUM_GRP; r++) begin
            if (code_ok && !found && grp_any[rank[r]]) begin
                win_d.valid = 1'b1;
                win_d.idx   = grp_idx[rank[r]];
                found       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_valid = win_q.valid;
    assign win_idx   = win_q.idx;

    // R2: nothing eligible, nothing reported next cycle
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> !win_valid);

    // R2: global enable low suppresses any winner
    p_en_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !win_valid);

    // R3: a legal order with any eligible line always yields a winner
    p_some_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_ok && (elig != '0)) |=> win_valid);

    // R7: illegal group codes never produce a winner
    p_rsvd_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ok |=> !win_valid);

    // R9: the reported line was eligible one cycle earlier
    p_was_elig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((($past(elig) >> win_idx) & NUM_IRQ'(1)) != '0));

    // R9: index is zero while there is no winner
    p_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_idx == '0));

    // R9: index stays inside the line range
    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_idx < IDX_W'(NUM_IRQ)));

endmodule

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic [5:0] irq_pend;
    logic [5:0] irq_mask;
    logic       irq_en;
    logic       win_valid;
    logic [2:0] win_idx;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] cur_cfg = 8'h00;

    always #10 clk = ~clk;

    irq_prio_resolver uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .irq_pend  (irq_pend),
        .irq_mask  (irq_mask),
        .irq_en    (irq_en),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    function automatic logic [3:0] model(input logic [7:0] c, input logic [5:0] p,
                                         input logic [5:0] m, input logic en);
        logic [5:0] e;
        logic [2:0] code;
        logic ok, found;
        int grp [3];
        int lst [6];
        logic [3:0] res;
        e    = en ? (p & m) : 6'd0;
        code = {c[4], c[2], c[1]};
        ok   = 1'b1;
        case (code)
            3'd1: grp = '{2, 0, 1};
            3'd2: grp = '{0, 1, 2};
            3'd3: grp = '{0, 2, 1};
            3'd4: grp = '{1, 2, 0};
            3'd5: grp = '{2, 1, 0};
            3'd6: grp = '{1, 0, 2};
            default: begin grp = '{0, 1, 2}; ok = 1'b0; end
        endcase
        for (int k = 0; k < 3; k++) begin
            case (grp[k])
                0: begin lst[2*k] = c[5] ? 3 : 5; lst[2*k+1] = c[5] ? 5 : 3; end
                1: begin lst[2*k] = c[3] ? 0 : 2; lst[2*k+1] = c[3] ? 2 : 0; end
                default: begin lst[2*k] = c[0] ? 4 : 1; lst[2*k+1] = c[0] ? 1 : 4; end
            endcase
        end
        res   = 4'd0;
        found = 1'b0;
        if (ok) begin
            for (int j = 0; j < 6; j++) begin
                if (!found && e[lst[j]]) begin
                    res   = {1'b1, 3'(lst[j])};
                    found = 1'b1;
                end
            end
        end
        return res;
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        n_vec++;
        if ({win_valid, win_idx} !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, win_valid, win_idx, exp[3], exp[2:0]);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = ~v;   // garbage with strobe low (R10)
        cur_cfg   = v;
    endtask

    task automatic vec(input logic [5:0] p, input logic [5:0] m, input logic en,
                       input string tag);
        @(negedge clk);
        irq_pend = p;
        irq_mask = m;
        irq_en   = en;
        @(posedge clk);
        #5;
        check(model(cur_cfg, p, m, en), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = 8'h00;
        irq_pend  = 6'h00;
        irq_mask  = 6'h00;
        irq_en    = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check(4'h0, "R1 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: cleared register carries an illegal code
        vec(6'h3F, 6'h3F, 1'b1, "R1 cleared config");

        // R4: group A ordering (code 010, A first)
        wr_cfg(8'h04);
        vec(6'h28, 6'h3F, 1'b1, "R4 bit5=0");
        wr_cfg(8'h24);
        vec(6'h28, 6'h3F, 1'b1, "R4 bit5=1");
        // R5: group B ordering (code 100, B first)
        wr_cfg(8'h10);
        vec(6'h05, 6'h3F, 1'b1, "R5 bit3=0");
        wr_cfg(8'h18);
        vec(6'h05, 6'h3F, 1'b1, "R5 bit3=1");
        // R6: group C ordering (code 001, C first)
        wr_cfg(8'h02);
        vec(6'h12, 6'h3F, 1'b1, "R6 bit0=0");
        wr_cfg(8'h03);
        vec(6'h12, 6'h3F, 1'b1, "R6 bit0=1");
        // R7: illegal codes
        wr_cfg(8'h16);
        vec(6'h3F, 6'h3F, 1'b1, "R7 code 111");
        wr_cfg(8'h29);
        vec(6'h3F, 6'h3F, 1'b1, "R7 code 000");
        // R8: reserved bits ignored
        wr_cfg(8'hC4);
        vec(6'h28, 6'h3F, 1'b1, "R8 reserved set");
        // R2: global enable low
        vec(6'h3F, 6'h3F, 1'b0, "R2 enable low");

        // R10: strobe low with different data keeps the old config
        wr_cfg(8'h04);
        @(negedge clk);
        cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_wdata = 8'h16;
        vec(6'h28, 6'h3F, 1'b1, "R10 no strobe hold");

        // R9: one-cycle latency
        vec(6'h01, 6'h3F, 1'b1, "R9 setup");
        @(negedge clk);
        irq_pend = 6'h00;
        #2;
        check(4'b1000, "R9 output before edge");
        @(posedge clk);
        #5;
        check(4'h0, "R9 output after edge");

        // Full sweep: every register value against every pending pattern
        for (int c = 0; c < 256; c++) begin
            wr_cfg(8'(c));
            for (int p = 0; p < 64; p++) begin
                vec(6'(p), 6'h3F, 1'b1, "R3/R4/R5/R6/R7/R8 sweep");
            end
            vec(6'h3F, 6'h3F, 1'b0, "R2 enable sweep");
        end

        // Mask crossing on two legal orderings
        for (int s = 0; s < 2; s++) begin
            wr_cfg(s == 0 ? 8'h06 : 8'h39);
            for (int p = 0; p < 64; p++) begin
                for (int m = 0; m < 64; m++) begin
                    vec(6'(p), 6'(m), 1'b1, "R2 mask sweep");
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule